// File: doc/BRIEF.md
# Loop-Replay Issue Queue

This block is an out-of-order issue queue that can hold a captured innermost loop and play it back without the front end. In ordinary operation, entries arrive from rename one per cycle into the next free slot of a circular buffer. An entry leaves the queue when the select logic issues it. An entry that arrives marked as part of a loop body is handled differently. It keeps its slot after issue, and only its issued flag is raised.

Once a loop has been buffered, a capture command supplies the slots of the first and last loop instructions and switches the queue into replay mode. The front end is gated for as long as the queue stays in that mode. Each cycle a replay cursor examines up to four slots from its position and replays the leading run of entries that are resident, marked and already issued. It returns the three architectural register numbers of each replayed entry to rename and clears their issued flags, so each entry must issue again before its next pass. The cursor moves forward by the number replayed. It jumps back to the loop's first slot after replaying the last one. A flush frees every entry that has already issued, drops all loop marks and returns the queue to ordinary operation.

Top module: `reuse_issue_queue`

## Requirements
- R1: After reset the queue is empty: count is 0, full is 0, reuse_mode is 0, rp_valid is 0, and slots fill from slot 0 upward.
- R2: In ordinary mode, when the queue is not full and flush is low, an insert is written to the write slot. Its loop mark is taken from ins_loop and its issued flag is 0. The write slot then advances by one, wrapping modulo DEPTH, and count rises by one on the next cycle.
- R3: Issuing a resident slot whose loop mark is 0 frees that slot on the next cycle.
- R4: Issuing a resident slot whose loop mark is 1 keeps it resident and sets its issued flag.
- R5: A loop_go without flush records loop_head and loop_tail, places the cursor at loop_head and raises reuse_mode on the next cycle.
- R6: In replay mode, lane k (k = 0..3) is valid exactly when slots cursor+0 .. cursor+k (modulo DEPTH) are all resident, marked and issued, and none of slots cursor+0 .. cursor+k-1 is loop_tail. Valid lanes always form a prefix. Lane k carries the 15-bit register list of slot cursor+k in rp_lrl[15k+14:15k], laid out exactly as it was inserted.
- R7: After a replay of n entries, the cursor moves to cursor+n. If the replayed run contains loop_tail, the cursor moves to loop_head instead.
- R8: Every replayed entry stays resident with its issued flag cleared.
- R9: Inserts are ignored while reuse_mode is 1: count and the write slot do not change.
- R10: Flush frees every resident slot whose issued flag is 1, clears the loop mark and issued flag of every remaining slot, and returns reuse_mode to 0 on the next cycle. Inserts, issues, captures and replays in the flush cycle have no effect.
- R11: full is 1 whenever the write slot is occupied. While full is 1, inserts are ignored.
- R12: qry_vld, qry_cb and qry_isb show, in the same cycle, the resident, loop-mark and issued flags of slot qry_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop issued entries and loop marks, leave replay mode |
| ins_valid | input | 1 | Insert request from rename |
| ins_loop | input | 1 | Inserted entry belongs to a loop body |
| ins_lrl | input | 15 | Architectural registers of the entry: rs [4:0], rt [9:5], rd [14:10] |
| iss_valid | input | 1 | Select logic issues a slot this cycle |
| iss_idx | input | 6 | Slot being issued |
| loop_go | input | 1 | Enter replay mode with the given loop bounds |
| loop_head | input | 6 | Slot of the first loop instruction |
| loop_tail | input | 6 | Slot of the last loop instruction |
| qry_idx | input | 6 | Slot looked at by the select logic |
| qry_vld | output | 1 | Slot qry_idx is resident |
| qry_cb | output | 1 | Slot qry_idx carries a loop mark |
| qry_isb | output | 1 | Slot qry_idx has issued |
| reuse_mode | output | 1 | Replay mode active; front end gated |
| rp_valid | output | 4 | Replay lane valid flags |
| rp_lrl | output | 60 | Register lists of the replay lanes, 15 bits per lane |
| full | output | 1 | Write slot occupied |
| count | output | 7 | Number of resident entries |

## Verification
The properties assume that the select logic only issues a resident slot whose issued flag is 0. They also assume that loop_go is raised only when slots loop_head through loop_tail hold a whole loop body of marked entries. The count-based properties further assume that issues are kept out of the cycles they observe, because an issue may legally free a slot. The stimulus respects these limits by construction. It issues every loop entry exactly once before each capture, re-issues a slot only after its flag has been cleared by a replay or a flush, and holds each insert, issue, capture and flush in its own cycle.

// File: rtl/riq_pkg.sv
package riq_pkg;
    // Architectural register fields carried per entry: rs, rt, rd
    localparam int unsigned REG_FIELDS = 3;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_REUSE  = 1'b1
    } riq_mode_e;
endpackage

// File: rtl/rq_popcount.sv
module rq_popcount #(
    parameter int unsigned W     = 64,
    localparam int unsigned CW   = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] ones_o
);
    always_comb begin
        ones_o = '0;
        for (int i = 0; i < W; i++) begin
            ones_o = ones_o + CW'(bits_i[i]);
        end
    end
endmodule

// File: rtl/rq_scan.sv
module rq_scan #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned LANES  = 4,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned N_W   = $clog2(LANES + 1)
) (
    input  logic                        en_i,
    input  logic [DEPTH-1:0]            vld_i,
    input  logic [DEPTH-1:0]            cb_i,
    input  logic [DEPTH-1:0]            isb_i,
    input  logic [IDX_W-1:0]            ptr_i,
    input  logic [IDX_W-1:0]            head_i,
    input  logic [IDX_W-1:0]            tail_i,
    output logic [LANES-1:0]            run_o,
    output logic [LANES-1:0][IDX_W-1:0] idx_o,
    output logic [IDX_W-1:0]            nxt_ptr_o
);
    logic [LANES-1:0] ready;
    logic [LANES-1:0] at_tail;
    logic [N_W-1:0]   n_run;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign idx_o[k]   = ptr_i + IDX_W'(k);
        assign ready[k]   = vld_i[idx_o[k]] & cb_i[idx_o[k]] & isb_i[idx_o[k]];
        assign at_tail[k] = (idx_o[k] == tail_i);
        if (k == 0) begin : g_first
            assign run_o[k] = en_i & ready[k];
        end else begin : g_next
            assign run_o[k] = run_o[k-1] & ready[k] & ~at_tail[k-1];
        end
    end

    always_comb begin
        n_run = '0;
        for (int k = 0; k < LANES; k++) begin
            n_run = n_run + N_W'(run_o[k]);
        end
    end

    assign nxt_ptr_o = (|(run_o & at_tail)) ? head_i : ptr_i + IDX_W'(n_run);
endmodule

// File: rtl/reuse_issue_queue.sv
module reuse_issue_queue
    import riq_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned LANES  = 4,
    parameter int unsigned AREG_W = 5,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned LRL_W = REG_FIELDS * AREG_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   ins_valid,
    input  logic                   ins_loop,
    input  logic [LRL_W-1:0]       ins_lrl,
    input  logic                   iss_valid,
    input  logic [IDX_W-1:0]       iss_idx,
    input  logic                   loop_go,
    input  logic [IDX_W-1:0]       loop_head,
    input  logic [IDX_W-1:0]       loop_tail,
    input  logic [IDX_W-1:0]       qry_idx,
    output logic                   qry_vld,
    output logic                   qry_cb,
    output logic                   qry_isb,
    output logic                   reuse_mode,
    output logic [LANES-1:0]       rp_valid,
    output logic [LANES*LRL_W-1:0] rp_lrl,
    output logic                   full,
    output logic [CNT_W-1:0]       count
);
    typedef struct packed {
        riq_mode_e                    mode;
        logic [IDX_W-1:0]             ptr;
        logic [IDX_W-1:0]             head;
        logic [IDX_W-1:0]             tail;
        logic [IDX_W-1:0]             wr;
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0]             cb;
        logic [DEPTH-1:0]             isb;
        logic [DEPTH-1:0][LRL_W-1:0]  lrl;
    } riq_state_t;

    riq_state_t st_q, st_d;

    logic [LANES-1:0]            run;
    logic [LANES-1:0][IDX_W-1:0] lane_idx;
    logic [IDX_W-1:0]            nxt_ptr;

    rq_scan #(
        .DEPTH (DEPTH),
        .LANES (LANES)
    ) u_scan (
        .en_i      (st_q.mode == MODE_REUSE),
        .vld_i     (st_q.vld),
        .cb_i      (st_q.cb),
        .isb_i     (st_q.isb),
        .ptr_i     (st_q.ptr),
        .head_i    (st_q.head),
        .tail_i    (st_q.tail),
        .run_o     (run),
        .idx_o     (lane_idx),
        .nxt_ptr_o (nxt_ptr)
    );

    rq_popcount #(
        .W (DEPTH)
    ) u_cnt (
        .bits_i (st_q.vld),
        .ones_o (count)
    );

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.vld  = st_q.vld & ~st_q.isb;
            st_d.cb   = '0;
            st_d.isb  = '0;
            st_d.mode = MODE_NORMAL;
        end else begin
            // issue: loop entries stay resident, others leave
            if (iss_valid && st_q.vld[iss_idx]) begin
                if (st_q.cb[iss_idx]) begin
                    st_d.isb[iss_idx] = 1'b1;
                end else begin
                    st_d.vld[iss_idx] = 1'b0;
                end
            end
            // replay: clear issued flag so the entry must issue again
            if (st_q.mode == MODE_REUSE) begin
                for (int k = 0; k < LANES; k++) begin
                    if (run[k]) begin
                        st_d.isb[lane_idx[k]] = 1'b0;
                    end
                end
                st_d.ptr = nxt_ptr;
            end
            // insert: front end gated during replay
            if (ins_valid && st_q.mode == MODE_NORMAL && !st_q.vld[st_q.wr]) begin
                st_d.vld[st_q.wr] = 1'b1;
                st_d.cb[st_q.wr]  = ins_loop;
                st_d.isb[st_q.wr] = 1'b0;
                st_d.lrl[st_q.wr] = ins_lrl;
                st_d.wr           = st_q.wr + 1'b1;
            end
            if (loop_go) begin
                st_d.mode = MODE_REUSE;
                st_d.head = loop_head;
                st_d.tail = loop_tail;
                st_d.ptr  = loop_head;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_NORMAL;
            st_q.ptr  <= '0;
            st_q.head <= '0;
            st_q.tail <= '0;
            st_q.wr   <= '0;
            st_q.vld  <= '0;
            st_q.cb   <= '0;
            st_q.isb  <= '0;
            st_q.lrl  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            rp_lrl[k*LRL_W +: LRL_W] = run[k] ? st_q.lrl[lane_idx[k]] : '0;
        end
    end

    assign rp_valid   = run;
    assign reuse_mode = (st_q.mode == MODE_REUSE);
    assign full       = st_q.vld[st_q.wr];
    assign qry_vld    = st_q.vld[qry_idx];
    assign qry_cb     = st_q.cb[qry_idx];
    assign qry_isb    = st_q.isb[qry_idx];
endmodule

// File: rtl/riq_chk.sv
module riq_chk #(
    parameter int unsigned LANES = 4,
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             ins_valid,
    input logic             iss_valid,
    input logic             loop_go,
    input logic             reuse_mode,
    input logic             full,
    input logic [LANES-1:0] rp_valid,
    input logic [CNT_W-1:0] count
);
    // R6
    lanes_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_valid & (rp_valid + LANES'(1))) == '0);

    // R1
    idle_no_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reuse_mode |-> rp_valid == '0);

    // R5
    enter_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_go && !flush |=> reuse_mode);

    // R10
    flush_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !reuse_mode);

    // R9
    gated_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reuse_mode && !flush && !iss_valid |=> count == $past(count));

    // R2
    insert_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !full && !reuse_mode && !flush && !iss_valid |=>
        count == $past(count) + CNT_W'(1));

    // R11
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && !flush && !iss_valid |=> count == $past(count));
endmodule

bind reuse_issue_queue riq_chk #(
    .LANES (LANES),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .ins_valid  (ins_valid),
    .iss_valid  (iss_valid),
    .loop_go    (loop_go),
    .reuse_mode (reuse_mode),
    .full       (full),
    .rp_valid   (rp_valid),
    .count      (count)
);

// File: tb/sim_reuse_issue_queue.sv
module sim_reuse_issue_queue;
    localparam int CYC = 10;

    logic        clk = 1'b0;
    logic        rst_n, flush, ins_valid, ins_loop, iss_valid, loop_go;
    logic [14:0] ins_lrl;
    logic [5:0]  iss_idx, loop_head, loop_tail, qry_idx;
    logic        qry_vld, qry_cb, qry_isb, reuse_mode, full;
    logic [3:0]  rp_valid;
    logic [59:0] rp_lrl;
    logic [6:0]  count;

    int nchk = 0;
    int nfail = 0;

    always #(CYC/2) clk = ~clk;

    reuse_issue_queue u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ins_valid(ins_valid), .ins_loop(ins_loop), .ins_lrl(ins_lrl),
        .iss_valid(iss_valid), .iss_idx(iss_idx),
        .loop_go(loop_go), .loop_head(loop_head), .loop_tail(loop_tail),
        .qry_idx(qry_idx), .qry_vld(qry_vld), .qry_cb(qry_cb), .qry_isb(qry_isb),
        .reuse_mode(reuse_mode), .rp_valid(rp_valid), .rp_lrl(rp_lrl),
        .full(full), .count(count)
    );

    // {issue, loop, slot, count after, {vld,cb,isb} of slot after}
    localparam logic [17:0] VEC [11] = '{
        {1'b0, 1'b0, 6'd0, 7'd1, 3'b100},
        {1'b0, 1'b1, 6'd1, 7'd2, 3'b110},
        {1'b0, 1'b1, 6'd2, 7'd3, 3'b110},
        {1'b0, 1'b1, 6'd3, 7'd4, 3'b110},
        {1'b0, 1'b1, 6'd4, 7'd5, 3'b110},
        {1'b0, 1'b1, 6'd5, 7'd6, 3'b110},
        {1'b1, 1'b0, 6'd0, 7'd5, 3'b000},
        {1'b1, 1'b0, 6'd1, 7'd5, 3'b111},
        {1'b1, 1'b0, 6'd2, 7'd5, 3'b111},
        {1'b1, 1'b0, 6'd3, 7'd5, 3'b111},
        {1'b1, 1'b0, 6'd5, 7'd5, 3'b111}
    };

    function automatic logic [14:0] lrl_of(int i);
        return {5'(i + 3), 5'(i + 2), 5'(i + 1)};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        flush = 0; ins_valid = 0; ins_loop = 0; ins_lrl = '0;
        iss_valid = 0; iss_idx = '0; loop_go = 0; loop_head = '0; loop_tail = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic peek(string req, int slot, logic [2:0] exp);
        qry_idx = 6'(slot);
        #1;
        chk(req, {61'd0, qry_vld, qry_cb, qry_isb}, {61'd0, exp});
    endtask

    task automatic ins(logic loop, int slot);
        ins_valid = 1; ins_loop = loop; ins_lrl = lrl_of(slot);
        tick();
    endtask

    task automatic iss(int slot);
        iss_valid = 1; iss_idx = 6'(slot);
        tick();
    endtask

    initial begin
        #(CYC * 200000);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        idle();
        qry_idx = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        // R1 reset state
        chk("R1 count", 64'(count), 0);
        chk("R1 mode/full/lanes", {58'd0, reuse_mode, full, rp_valid}, 0);

        // table: fill then issue (R2 R3 R4 R12)
        for (int v = 0; v < 11; v++) begin
            if (VEC[v][17]) iss(int'(VEC[v][15:10]));
            else ins(VEC[v][16], int'(VEC[v][15:10]));
            chk(VEC[v][17] ? "R3/R4 count" : "R2 count", 64'(count), 64'(VEC[v][9:3]));
            peek(VEC[v][17] ? "R3/R4 R12 flags" : "R2 R12 flags",
                 int'(VEC[v][15:10]), VEC[v][2:0]);
        end
        iss(4);
        peek("R4 slot4", 4, 3'b111);

        // R5 capture loop slots 1..5
        loop_go = 1; loop_head = 6'd1; loop_tail = 6'd5;
        tick();
        chk("R5 reuse_mode", 64'(reuse_mode), 1);
        chk("R6 four lanes", 64'(rp_valid), 64'hf);
        chk("R6 lane lists", 64'(rp_lrl),
            64'({lrl_of(4), lrl_of(3), lrl_of(2), lrl_of(1)}));
        tick();
        chk("R7 cursor+4 then tail only", 64'(rp_valid), 64'h1);
        chk("R7 lane0 is slot5", 64'(rp_lrl[14:0]), 64'(lrl_of(5)));
        peek("R8 replayed slot2 cleared", 2, 3'b110);
        tick();
        chk("R8 nothing replayable", 64'(rp_valid), 0);
        // R9 insert ignored in replay mode
        ins(1'b0, 6);
        chk("R9 count held", 64'(count), 5);
        peek("R9 slot6 empty", 6, 3'b000);
        iss(1);
        chk("R7 wrapped to head, run stops at slot2", 64'(rp_valid), 64'h1);
        chk("R7 lane0 is slot1", 64'(rp_lrl[14:0]), 64'(lrl_of(1)));
        tick();
        chk("R6 slot2 not issued", 64'(rp_valid), 0);
        peek("R8 slot1 cleared", 1, 3'b110);
        iss(3);
        peek("R4 slot3 issued in replay", 3, 3'b111);

        // R10 flush
        flush = 1;
        tick();
        chk("R10 mode", 64'(reuse_mode), 0);
        chk("R10 count", 64'(count), 4);
        peek("R10 issued slot freed", 3, 3'b000);
        peek("R10 mark dropped", 4, 3'b100);
        iss(4);
        chk("R3 after flush", 64'(count), 3);

        // R11 fill slots 6..63 and 0
        for (int i = 0; i < 59; i++) ins(1'b0, (6 + i) % 64);
        chk("R11 count", 64'(count), 62);
        chk("R11 full", 64'(full), 1);
        ins(1'b0, 1);
        chk("R11 insert ignored", 64'(count), 62);
        iss(1);
        chk("R11 slot freed", {57'd0, full, count}, {57'd0, 1'b0, 7'd61});
        ins(1'b1, 1);
        chk("R11 refill", {57'd0, full, count}, {57'd0, 1'b1, 7'd62});
        peek("R2 R12 refill flags", 1, 3'b110);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule